// File: doc/BRIEF.md
# Flash Byte-Program and Erase Sequencer

This block runs a small on-chip code store, held in a register array, behind a parallel programming port. An external programmer places an address, a data byte and a mode code on the port, asserts the high-voltage qualifier, and raises the program strobe once. The block then runs a self-timed byte write or a whole-array erase. It reports progress on a ready line and, for writes, through data polling on the read bus.

The same port returns stored bytes for verification, gated by an enable from a separate lock-bit block. It also returns three fixed identification bytes in signature mode. A second enable from the lock-bit block gates programming. Commands that arrive while an operation is running are dropped without any error indication.

Top module: `flash_prog_seq`

## Requirements
- R1: During and after reset, `ready` is 1 and every location reads FFh in verify mode (`prog_mode` = 2'b00).
- R2: A strobe rising edge in program mode (2'b01), with `hv_ok` and `prog_allowed` high, stores `prog_din` at `prog_addr`. Once `ready` returns high, a verify read of that address gives the stored byte.
- R3: A byte write holds `ready` low for exactly WRITE_CYCLES clock cycles. The first low cycle follows the clock edge that sees the strobe rise.
- R4: While a write runs, a verify read of the address being written returns the inverted bit 7 of the byte being written on bit 7, with bits 6:0 zero. A verify read of any other address returns 00h.
- R5: A strobe rising edge in erase mode (2'b10) with `hv_ok` high holds `ready` low for exactly ERASE_CYCLES cycles. Verify reads return 00h during the erase, and every location reads FFh after it.
- R6: In signature mode (2'b11), reads at 000h, 100h and 200h return 1Eh, 52h and 06h. Any other address returns 00h.
- R7: A verify read while `verify_allowed` is low returns 00h.
- R8: A strobe rising edge while `ready` is low neither starts nor restarts an operation, and it does not change the array.
- R9: A strobe rising edge while `hv_ok` is low starts nothing, and the array keeps its contents.
- R10: A program command while `prog_allowed` is low is ignored. Erase does not depend on `prog_allowed`.
- R11: Only a 0-to-1 transition of `prog_strobe` starts an operation. Holding the strobe high starts nothing further.
- R12: Reads in program or erase mode return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_addr | input | ADDR_W | Byte address for programming and reads |
| prog_din | input | DATA_W | Byte to program |
| prog_mode | input | 2 | 00 verify, 01 program, 10 erase, 11 signature |
| hv_ok | input | 1 | High-voltage qualifier for program and erase |
| prog_strobe | input | 1 | Program strobe; a rising edge starts a command |
| prog_allowed | input | 1 | Lock gate: programming permitted |
| verify_allowed | input | 1 | Lock gate: code verify permitted |
| rd_dout | output | DATA_W | Read data, combinational from address and mode |
| ready | output | 1 | High when idle, low while busy |

## Verification
The bench measures busy length to the cycle. A timer that is off by one would show up as a write or erase window one cycle long or short. It polls the written address during a write with bit 7 both 0 and 1, so a design that returned true data, the old contents or an uninverted bit would mismatch. It fires erase and program strobes into a running write, and holds the strobe high across the end of a write. A design that latched commands while busy or acted on strobe level instead of its edge would change the array or the ready timing. It also reads with each lock gate low and in every mode, so any leak of array data through the wrong mode shows up.

// File: rtl/flash_prog_pkg.sv
// Shared types and constants for the flash programming sequencer.
// Assumes addresses are at least 10 bits wide so the signature slots exist.
package flash_prog_pkg;

    typedef enum logic [1:0] {
        MODE_VERIFY = 2'b00,
        MODE_PROG   = 2'b01,
        MODE_ERASE  = 2'b10,
        MODE_SIG    = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WRITE = 2'b01,
        ST_ERASE = 2'b10
    } state_e;

    localparam int SIG_ADDR_0 = 'h000;
    localparam int SIG_ADDR_1 = 'h100;
    localparam int SIG_ADDR_2 = 'h200;
    localparam logic [7:0] SIG_BYTE_0 = 8'h1E;
    localparam logic [7:0] SIG_BYTE_1 = 8'h52;
    localparam logic [7:0] SIG_BYTE_2 = 8'h06;

endpackage

// File: rtl/flash_seq_ctrl.sv
// Command sequencer: detects the strobe rising edge and accepts a program
// or erase command only when idle and qualified. It then runs a down-counter
// for the self-timed interval and pulses a commit for one cycle at the end.
// Assumes WRITE_CYCLES and ERASE_CYCLES are both at least 1.
module flash_seq_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 16,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              hv_ok,
    input  logic              prog_allowed,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output state_e            state,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              commit_wr,
    output logic              commit_erase
);

    localparam int MAX_CYC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             strobe_q;
    logic             strobe_rise;
    logic [CNT_W-1:0] cnt;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign strobe_rise = strobe & ~strobe_q;

    // Accept a command when idle, then count down the self-timed interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (strobe_rise && hv_ok) begin
                        if (mode == MODE_PROG && prog_allowed) begin
                            state   <= ST_WRITE;
                            cnt     <= CNT_W'(WRITE_CYCLES - 1);
                            wr_addr <= addr;
                            wr_data <= din;
                        end else if (mode == MODE_ERASE) begin
                            state <= ST_ERASE;
                            cnt   <= CNT_W'(ERASE_CYCLES - 1);
                        end
                    end
                end
                default: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Commit pulses on the last busy cycle of each operation.
    assign commit_wr    = (state == ST_WRITE) && (cnt == '0);
    assign commit_erase = (state == ST_ERASE) && (cnt == '0);

endmodule

// File: rtl/flash_cell_array.sv
// Code store modelled as a register array with an asynchronous read port.
// Reset and erase both fill it with all ones, and a single byte is written on commit.
// Assumes commit_wr and commit_erase are never high together.
module flash_cell_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_wr,
    input  logic              commit_erase,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Fill on reset or erase, store one byte on write commit.
    always_ff @(posedge clk) begin
        if (!rst_n || commit_erase) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (commit_wr) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/flash_read_path.sv
// Read multiplexer: chooses signature bytes, polling status, gated array data
// or zero, from the mode, the lock gate and the sequencer state.
// Assumes DATA_W is at least 8, since the signature bytes are 8 bits wide.
module flash_read_path
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  mode_e             mode,
    input  state_e            state,
    input  logic              verify_allowed,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_msb,
    input  logic [DATA_W-1:0] cell_data,
    output logic [DATA_W-1:0] dout
);

    // Select the byte presented on the read bus.
    always_comb begin
        dout = '0;
        if (mode == MODE_SIG) begin
            if (int'(addr) == SIG_ADDR_0)      dout = DATA_W'(SIG_BYTE_0);
            else if (int'(addr) == SIG_ADDR_1) dout = DATA_W'(SIG_BYTE_1);
            else if (int'(addr) == SIG_ADDR_2) dout = DATA_W'(SIG_BYTE_2);
        end else if (mode == MODE_VERIFY && verify_allowed) begin
            if (state == ST_IDLE) begin
                dout = cell_data;
            end else if (state == ST_WRITE && addr == wr_addr) begin
                dout[DATA_W-1] = ~wr_msb;
            end
        end
    end

endmodule

// File: rtl/flash_prog_seq.sv
// Top of the flash programming sequencer: ties the command sequencer, the
// code store and the read path together. Busy is reported active-low on ready.
// Assumes all inputs are synchronous to clk.
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 16,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_din,
    input  logic [1:0]        prog_mode,
    input  logic              hv_ok,
    input  logic              prog_strobe,
    input  logic              prog_allowed,
    input  logic              verify_allowed,
    output logic [DATA_W-1:0] rd_dout,
    output logic              ready
);

    mode_e             mode;
    state_e            state;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              commit_wr;
    logic              commit_erase;
    logic [DATA_W-1:0] cell_data;

    assign mode  = mode_e'(prog_mode);
    assign ready = (state == ST_IDLE);

    flash_seq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe(prog_strobe), .hv_ok(hv_ok),
        .prog_allowed(prog_allowed), .mode(mode), .addr(prog_addr), .din(prog_din),
        .state(state), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_wr(commit_wr), .commit_erase(commit_erase)
    );

    flash_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .commit_wr(commit_wr), .commit_erase(commit_erase),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(prog_addr), .rd_data(cell_data)
    );

    flash_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_read (
        .mode(mode), .state(state), .verify_allowed(verify_allowed), .addr(prog_addr),
        .wr_addr(wr_addr), .wr_msb(wr_data[DATA_W-1]), .cell_data(cell_data),
        .dout(rd_dout)
    );

endmodule

// File: rtl/flash_prog_seq_chk.sv
// Property checker for the flash programming sequencer, bound to the top.
// Watches only top-level ports. Busy length is measured with a local counter.
module flash_prog_seq_chk #(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 16,
    parameter int ERASE_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [1:0]        prog_mode,
    input logic              hv_ok,
    input logic              verify_allowed,
    input logic [DATA_W-1:0] rd_dout,
    input logic              ready
);

    int unsigned low_cnt;

    // Count consecutive cycles with ready low.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_cnt <= 0;
        else if (!ready) low_cnt <= low_cnt + 1;
        else            low_cnt <= 0;
    end

    // R3, R5, R8: every busy window has one of the two fixed lengths.
    assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cnt == WRITE_CYCLES || low_cnt == ERASE_CYCLES));

    // R9: nothing starts without the high-voltage qualifier.
    assert_no_start_without_hv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !hv_ok) |=> ready);

    // R6: signature slot 0 returns the fixed byte.
    assert_sig_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode == 2'b11 && prog_addr == '0) |-> rd_dout == DATA_W'(8'h1E));

    // R7: blocked verify reads are zero.
    assert_verify_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode == 2'b00 && !verify_allowed) |-> rd_dout == '0);

    // R12: command-mode reads are zero.
    assert_cmd_mode_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode == 2'b01 || prog_mode == 2'b10) |-> rd_dout == '0);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_mode(prog_mode),
    .hv_ok(hv_ok), .verify_allowed(verify_allowed), .rd_dout(rd_dout), .ready(ready)
);

// File: tb/flash_prog_seq_tb.sv
// Self-checking bench: a behavioural reference model is advanced on every
// rising edge and compared with the outputs between edges.
module flash_prog_seq_tb;

    localparam int AW = 10;
    localparam int DW = 8;
    localparam int WC = 16;
    localparam int EC = 40;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [DW-1:0] prog_din = '0;
    logic [1:0]    prog_mode = 2'b00;
    logic          hv_ok = 1'b0;
    logic          prog_strobe = 1'b0;
    logic          prog_allowed = 1'b1;
    logic          verify_allowed = 1'b1;
    logic [DW-1:0] rd_dout;
    logic          ready;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    int low_run = 0;
    logic last_ready = 1'b1;

    // Reference model state
    int            m_kind = 0;   // 0 idle, 1 write, 2 erase
    int            m_cnt = 0;
    logic [AW-1:0] m_a = '0;
    logic [DW-1:0] m_d = '0;
    logic          m_sq = 1'b0;
    logic [DW-1:0] m_mem [DEPTH];

    always #2 clk = ~clk;

    flash_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_din(prog_din),
        .prog_mode(prog_mode), .hv_ok(hv_ok), .prog_strobe(prog_strobe),
        .prog_allowed(prog_allowed), .verify_allowed(verify_allowed),
        .rd_dout(rd_dout), .ready(ready)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] model_dout();
        if (prog_mode == 2'b11) begin
            if (prog_addr == 10'h000) return 8'h1E;
            if (prog_addr == 10'h100) return 8'h52;
            if (prog_addr == 10'h200) return 8'h06;
            return 8'h00;
        end
        if (prog_mode != 2'b00 || !verify_allowed || m_kind == 2) return 8'h00;
        if (m_kind == 1) return (prog_addr == m_a) ? {~m_d[7], 7'b0} : 8'h00;
        return m_mem[prog_addr];
    endfunction

    task automatic model_step();
        logic rise;
        if (!rst_n) begin
            m_kind = 0; m_sq = 1'b0;
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            return;
        end
        rise = prog_strobe && !m_sq;
        m_sq = prog_strobe;
        if (m_kind != 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                if (m_kind == 1) m_mem[m_a] = m_d;
                else foreach (m_mem[i]) m_mem[i] = 8'hFF;
                m_kind = 0;
            end
        end else if (rise && hv_ok) begin
            if (prog_mode == 2'b01 && prog_allowed) begin
                m_kind = 1; m_cnt = WC; m_a = prog_addr; m_d = prog_din;
            end else if (prog_mode == 2'b10) begin
                m_kind = 2; m_cnt = EC;
            end
        end
    endtask

    // One cycle: compare (optionally with an extra expected read), then advance.
    task automatic cyc_x(string tag, bit use_x, logic [DW-1:0] exp);
        #1;
        check({cur_req, " ready"}, ready, (m_kind == 0));
        check({cur_req, " dout"}, rd_dout, model_dout());
        if (use_x) check(tag, rd_dout, exp);
        last_ready = ready;
        if (!ready) low_run++;
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic cyc();
        cyc_x("", 1'b0, '0);
    endtask

    task automatic pulse(logic [1:0] mode, logic [AW-1:0] a, logic [DW-1:0] d);
        prog_mode = mode; prog_addr = a; prog_din = d; prog_strobe = 1'b1;
        cyc();
        prog_strobe = 1'b0;
        cyc();
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 1000; i++) begin
            cyc();
            if (last_ready) break;
        end
    endtask

    task automatic read_chk(string tag, logic [1:0] mode, logic [AW-1:0] a, logic [DW-1:0] exp);
        prog_mode = mode; prog_addr = a;
        cyc_x(tag, 1'b1, exp);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        foreach (m_mem[i]) m_mem[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cyc();                         // reset still low, model in reset
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        read_chk("R1 reset read", 2'b00, 10'h005, 8'hFF);
        read_chk("R1 reset read", 2'b00, 10'h3FF, 8'hFF);

        // R2, R3, R4: program with bit 7 clear, poll during write
        cur_req = "R4"; hv_ok = 1'b1; low_run = 0;
        pulse(2'b01, 10'h005, 8'h3C);
        read_chk("R4 poll same addr", 2'b00, 10'h005, 8'h80);
        read_chk("R4 poll other addr", 2'b00, 10'h006, 8'h00);
        wait_ready();
        check("R3 write busy length", low_run, WC);
        cur_req = "R2";
        read_chk("R2 readback", 2'b00, 10'h005, 8'h3C);

        // R4 with bit 7 set
        cur_req = "R4"; low_run = 0;
        pulse(2'b01, 10'h123, 8'hC5);
        read_chk("R4 poll msb set", 2'b00, 10'h123, 8'h00);
        // R8: erase and program strobes during the write are ignored
        cur_req = "R8";
        pulse(2'b10, 10'h000, 8'h00);
        pulse(2'b01, 10'h124, 8'h77);
        wait_ready();
        check("R8 busy not restarted", low_run, WC);
        read_chk("R2 readback msb", 2'b00, 10'h123, 8'hC5);
        read_chk("R8 no stray write", 2'b00, 10'h124, 8'hFF);
        read_chk("R8 no erase", 2'b00, 10'h005, 8'h3C);

        // R6: signature reads
        cur_req = "R6";
        read_chk("R6 sig 000", 2'b11, 10'h000, 8'h1E);
        read_chk("R6 sig 100", 2'b11, 10'h100, 8'h52);
        read_chk("R6 sig 200", 2'b11, 10'h200, 8'h06);
        read_chk("R6 sig other", 2'b11, 10'h005, 8'h00);

        // R7: verify blocked by lock gate
        cur_req = "R7"; verify_allowed = 1'b0;
        read_chk("R7 blocked", 2'b00, 10'h005, 8'h00);
        verify_allowed = 1'b1;

        // R12: reads in command modes
        cur_req = "R12";
        read_chk("R12 prog mode read", 2'b01, 10'h005, 8'h00);
        read_chk("R12 erase mode read", 2'b10, 10'h005, 8'h00);

        // R9: no high-voltage qualifier
        cur_req = "R9"; hv_ok = 1'b0;
        pulse(2'b01, 10'h005, 8'h00);
        check("R9 ready stays high", ready, 1'b1);
        pulse(2'b10, 10'h005, 8'h00);
        read_chk("R9 array unchanged", 2'b00, 10'h005, 8'h3C);
        hv_ok = 1'b1;

        // R10: programming locked, erase still works later
        cur_req = "R10"; prog_allowed = 1'b0;
        pulse(2'b01, 10'h005, 8'h11);
        check("R10 ready stays high", ready, 1'b1);
        read_chk("R10 array unchanged", 2'b00, 10'h005, 8'h3C);

        // R11: strobe held high starts only one write
        cur_req = "R11"; prog_allowed = 1'b1;
        prog_mode = 2'b01; prog_addr = 10'h040; prog_din = 8'h5A; prog_strobe = 1'b1;
        cyc();
        wait_ready();
        prog_addr = 10'h041; prog_din = 8'h22;
        repeat (4) cyc();
        check("R11 no second start", ready, 1'b1);
        prog_strobe = 1'b0;
        cyc();
        read_chk("R11 first write", 2'b00, 10'h040, 8'h5A);
        read_chk("R11 no second write", 2'b00, 10'h041, 8'hFF);

        // R5: erase with programming locked
        cur_req = "R5"; prog_allowed = 1'b0; low_run = 0;
        pulse(2'b10, 10'h000, 8'h00);
        read_chk("R5 read during erase", 2'b00, 10'h005, 8'h00);
        wait_ready();
        check("R5 erase busy length", low_run, EC);
        read_chk("R5 erased 005", 2'b00, 10'h005, 8'hFF);
        read_chk("R5 erased 123", 2'b00, 10'h123, 8'hFF);
        read_chk("R5 erased 040", 2'b00, 10'h040, 8'hFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule